// File: doc/BRIEF.md
# Luminance Effects Stage

This block sits in a video luminance path and changes each 8-bit sample as it streams past. A qualified sample enters with `in_valid`. `in_sol` marks the first sample of a line and `in_sof` marks the first sample of a frame. The block scales the sample by a programmable gain and adds a programmable pedestal. It can then apply three optional effects: a two-level threshold (slice), a low-bit discard (solarization) and a photographic negative. After these it can pixelate the picture into square blocks and can blank the output. It also passes a sepia request flag to the chroma path, aligned with each sample.

All control values are static register inputs. Every result leaves the block two clock cycles after its sample enters. The valid flag and the line and frame markers travel with the sample. The mosaic effect keeps one line of held samples, so that the top line of each block row can be repeated on the lines below it.

Top module: `luma_fx_top`

## Requirements
- R1: `out_valid`, `out_sol` and `out_sof` equal `in_valid`, `in_valid & in_sol` and `in_valid & in_sof` from two clock edges earlier, and each sample's result appears on `out_luma` in that same cycle.
- R2: With `cfg_gain_x2`=0 the gain stage yields floor(sample × `cfg_gain` / 32). With `cfg_gain_x2`=1 it yields floor(sample × `cfg_gain` / 16). Results above 255 become 255.
- R3: The pedestal stage adds `cfg_pedestal` to the gained value and limits the sum to 255.
- R4: When `cfg_clear`=1 is sampled with a sample, that sample's `out_luma` is 0.
- R5: With `cfg_slice_en`=1 the value becomes 255 or 0, depending on whether it is strictly greater than `cfg_slice_level`. With `cfg_slice_pol`=1, a value above the level gives 255 and any other value gives 0. With `cfg_slice_pol`=0 the two results are swapped.
- R6: With `cfg_sol_en`=1, `cfg_sol_sel` codes 0, 1, 2 and 3 force the lowest 3, 4, 5 and 6 bits of the value to zero.
- R7: `cfg_positive`=1 leaves the value unchanged. `cfg_positive`=0 replaces it with 255 minus the value.
- R8: With `cfg_mos_en`=1 the block size is N = 4, 8, 16 or 32 for `cfg_mos_size` codes 0 to 3. On a block row's first line, sample x of the line (counted from 0 at `in_sol`) outputs the sample at position x − (x mod N) of that line.
- R9: The line that carries `in_sof` starts block row 0, and every N lines start a new block row. Each of the N−1 lines that follow a block row's first line repeats that first line's mosaic output at the same position.
- R10: The stages act in this order: gain, pedestal, slice, solarization, inversion, mosaic, clear.
- R11: `out_sepia` carries `cfg_sepia_en` as sampled with the sample now on `out_luma`.
- R12: After reset, `out_valid`, `out_sol`, `out_sof`, `out_sepia` and `out_luma` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_sol | input | 1 | First sample of a line |
| in_sof | input | 1 | First sample of a frame |
| in_luma | input | 8 | Input luminance sample |
| cfg_gain | input | 6 | Gain numerator over 32 |
| cfg_gain_x2 | input | 1 | Double the gain |
| cfg_pedestal | input | 8 | Offset added after gain |
| cfg_clear | input | 1 | Blank the output |
| cfg_slice_en | input | 1 | Enable the slice |
| cfg_slice_pol | input | 1 | Slice polarity, 1 = positive |
| cfg_slice_level | input | 8 | Slice threshold |
| cfg_sol_en | input | 1 | Enable solarization |
| cfg_sol_sel | input | 2 | Count of low bits cleared, minus 3 |
| cfg_positive | input | 1 | 1 = normal picture, 0 = negative |
| cfg_mos_en | input | 1 | Enable mosaic |
| cfg_mos_size | input | 2 | Mosaic block size code |
| cfg_sepia_en | input | 1 | Sepia request |
| out_valid | output | 1 | Output sample qualifier |
| out_sol | output | 1 | Delayed line-start marker |
| out_sof | output | 1 | Delayed frame-start marker |
| out_luma | output | 8 | Processed luminance |
| out_sepia | output | 1 | Sepia flag aligned with the sample |

## Verification
Every result is due on the second rising edge after the edge that captures its sample. The bench drives inputs on the falling edge and reads the outputs on the falling edge that follows that second rising edge. In the mosaic streams a new sample enters on every cycle, so each check refers to the sample driven two falling edges earlier. Its expected value is worked out from its line and column within the block. The latency check also confirms that nothing appears after one edge and that the valid flag drops after the third edge.

// File: rtl/luma_fx_pkg.sv
package luma_fx_pkg;

    localparam int PIX_W        = 8;
    localparam int GAIN_W       = 6;
    localparam int GAIN_FRAC    = 5;
    localparam int SOL_BASE     = 3;
    localparam int MOS_BASE_LOG = 2;
    localparam int SPAN_W       = MOS_BASE_LOG + 4;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        MOS_N4  = 2'd0,
        MOS_N8  = 2'd1,
        MOS_N16 = 2'd2,
        MOS_N32 = 2'd3
    } mos_size_e;

    typedef struct packed {
        logic valid;
        logic sol;
        logic sof;
        logic clear;
        logic sepia;
        pix_t luma;
    } stage_t;

    function automatic pix_t sat_add(input pix_t a, input pix_t b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[PIX_W] ? '1 : s[PIX_W-1:0];
    endfunction

    function automatic pix_t sol_mask(input logic [1:0] sel);
        pix_t m;
        m = '1;
        m = m << (SOL_BASE + int'(sel));
        return m;
    endfunction

    function automatic logic [SPAN_W-1:0] mos_span(input mos_size_e sel);
        logic [SPAN_W-1:0] n;
        n = SPAN_W'(1) << (MOS_BASE_LOG + int'(sel));
        return n - SPAN_W'(1);
    endfunction

endpackage

// File: rtl/luma_fx_point.sv
module luma_fx_point
    import luma_fx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_sof,
    input  pix_t              in_luma,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              cfg_gain_x2,
    input  pix_t              cfg_pedestal,
    input  logic              cfg_clear,
    input  logic              cfg_slice_en,
    input  logic              cfg_slice_pol,
    input  pix_t              cfg_slice_level,
    input  logic              cfg_sol_en,
    input  logic [1:0]        cfg_sol_sel,
    input  logic              cfg_positive,
    input  logic              cfg_sepia_en,
    output stage_t            pt_q
);

    localparam int PROD_W = PIX_W + GAIN_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    pix_t              gained;
    pix_t              lifted;
    pix_t              sliced;
    pix_t              solar;
    pix_t              shaded;
    stage_t            pt_d;

    always_comb begin
        prod   = PROD_W'(in_luma) * PROD_W'(cfg_gain);
        scaled = cfg_gain_x2 ? (prod >> (GAIN_FRAC - 1)) : (prod >> GAIN_FRAC);
        gained = (|scaled[PROD_W-1:PIX_W]) ? '1 : scaled[PIX_W-1:0];
        lifted = sat_add(gained, cfg_pedestal);
        if (cfg_slice_en)
            sliced = ((lifted > cfg_slice_level) == cfg_slice_pol) ? '1 : '0;
        else
            sliced = lifted;
        solar  = cfg_sol_en ? (sliced & sol_mask(cfg_sol_sel)) : sliced;
        shaded = cfg_positive ? solar : ~solar;

        pt_d.valid = in_valid;
        pt_d.sol   = in_valid & in_sol;
        pt_d.sof   = in_valid & in_sof;
        pt_d.clear = cfg_clear;
        pt_d.sepia = cfg_sepia_en;
        pt_d.luma  = shaded;
    end

    always_ff @(posedge clk) begin
        if (rst) pt_q <= '0;
        else     pt_q <= pt_d;
    end

    // R5: an enabled slice leaves only the two extreme codes
    a_r5_slice_two_level: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && cfg_slice_en && !cfg_sol_en))
        |-> (pt_q.luma == 8'h00 || pt_q.luma == 8'hFF));

    // R6: solarized samples carry no low bits when not inverted
    a_r6_low_bits_cleared: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && cfg_sol_en && cfg_positive))
        |-> ((pt_q.luma & ~sol_mask($past(cfg_sol_sel))) == '0));

endmodule

// File: rtl/luma_fx_mosaic.sv
module luma_fx_mosaic
    import luma_fx_pkg::*;
#(
    parameter int LINE_MAX = 768
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      s_valid,
    input  logic      s_sol,
    input  logic      s_sof,
    input  pix_t      s_luma,
    input  mos_size_e cfg_size,
    output pix_t      mos_luma
);

    localparam int              XW     = $clog2(LINE_MAX);
    localparam logic [XW-1:0]   X_LAST = XW'(LINE_MAX - 1);

    logic [XW-1:0]     x_q,  cur_x;
    logic [SPAN_W-1:0] h_q,  cur_h;
    logic [SPAN_W-1:0] v_q,  cur_v;
    logic [SPAN_W-1:0] span;
    pix_t              hold_q, held;
    pix_t              line_mem [LINE_MAX];

    always_comb begin
        span = mos_span(cfg_size);
        if (s_sol)              cur_x = '0;
        else if (x_q == X_LAST) cur_x = x_q;
        else                    cur_x = x_q + XW'(1);

        if (s_sol || h_q >= span) cur_h = '0;
        else                      cur_h = h_q + SPAN_W'(1);

        if (s_sof)      cur_v = '0;
        else if (s_sol) cur_v = (v_q >= span) ? '0 : v_q + SPAN_W'(1);
        else            cur_v = v_q;

        held     = (cur_h == '0) ? s_luma : hold_q;
        mos_luma = (cur_v == '0) ? held : line_mem[cur_x];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            h_q    <= '0;
            v_q    <= '0;
            hold_q <= '0;
        end else if (s_valid) begin
            x_q    <= cur_x;
            h_q    <= cur_h;
            v_q    <= cur_v;
            hold_q <= held;
        end
    end

    always_ff @(posedge clk) begin
        if (s_valid && cur_v == '0)
            line_mem[cur_x] <= held;
    end

    // R9: the row counter restarts at every frame-start sample
    a_r9_row_restart: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(s_valid && s_sof)) |-> (v_q == '0));

endmodule

// File: rtl/luma_fx_top.sv
module luma_fx_top
    import luma_fx_pkg::*;
#(
    parameter int LINE_MAX = 768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sol,
    input  logic       in_sof,
    input  logic [7:0] in_luma,
    input  logic [5:0] cfg_gain,
    input  logic       cfg_gain_x2,
    input  logic [7:0] cfg_pedestal,
    input  logic       cfg_clear,
    input  logic       cfg_slice_en,
    input  logic       cfg_slice_pol,
    input  logic [7:0] cfg_slice_level,
    input  logic       cfg_sol_en,
    input  logic [1:0] cfg_sol_sel,
    input  logic       cfg_positive,
    input  logic       cfg_mos_en,
    input  logic [1:0] cfg_mos_size,
    input  logic       cfg_sepia_en,
    output logic       out_valid,
    output logic       out_sol,
    output logic       out_sof,
    output logic [7:0] out_luma,
    output logic       out_sepia
);

    stage_t pt_q;
    pix_t   mos_luma;
    pix_t   fx_luma;

    luma_fx_point u_point (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .in_sol          (in_sol),
        .in_sof          (in_sof),
        .in_luma         (in_luma),
        .cfg_gain        (cfg_gain),
        .cfg_gain_x2     (cfg_gain_x2),
        .cfg_pedestal    (cfg_pedestal),
        .cfg_clear       (cfg_clear),
        .cfg_slice_en    (cfg_slice_en),
        .cfg_slice_pol   (cfg_slice_pol),
        .cfg_slice_level (cfg_slice_level),
        .cfg_sol_en      (cfg_sol_en),
        .cfg_sol_sel     (cfg_sol_sel),
        .cfg_positive    (cfg_positive),
        .cfg_sepia_en    (cfg_sepia_en),
        .pt_q            (pt_q)
    );

    luma_fx_mosaic #(.LINE_MAX(LINE_MAX)) u_mosaic (
        .clk      (clk),
        .rst      (rst),
        .s_valid  (pt_q.valid),
        .s_sol    (pt_q.sol),
        .s_sof    (pt_q.sof),
        .s_luma   (pt_q.luma),
        .cfg_size (mos_size_e'(cfg_mos_size)),
        .mos_luma (mos_luma)
    );

    always_comb begin
        if (pt_q.clear)     fx_luma = '0;
        else if (cfg_mos_en) fx_luma = mos_luma;
        else                 fx_luma = pt_q.luma;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
            out_luma  <= '0;
            out_sepia <= 1'b0;
        end else begin
            out_valid <= pt_q.valid;
            out_sol   <= pt_q.sol;
            out_sof   <= pt_q.sof;
            if (pt_q.valid) begin
                out_luma  <= fx_luma;
                out_sepia <= pt_q.sepia;
            end
        end
    end

    // R1: valid flag trails the input by exactly two edges
    a_r1_two_cycle_valid: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

    // R4: a blanked sample leaves as zero
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(in_valid, 2) && $past(cfg_clear, 2))
        |-> (out_luma == 8'h00));

    // R11: sepia flag matches the request sampled with the sample
    a_r11_sepia_aligned: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && out_valid)
        |-> (out_sepia == $past(cfg_sepia_en, 2)));

endmodule

// File: tb/luma_fx_top_bench.sv
`timescale 1ns/1ps
module luma_fx_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [7:0] in_luma = '0;
    logic [5:0] cfg_gain = 6'd32;
    logic       cfg_gain_x2 = 1'b0;
    logic [7:0] cfg_pedestal = '0;
    logic       cfg_clear = 1'b0;
    logic       cfg_slice_en = 1'b0, cfg_slice_pol = 1'b0;
    logic [7:0] cfg_slice_level = '0;
    logic       cfg_sol_en = 1'b0;
    logic [1:0] cfg_sol_sel = '0;
    logic       cfg_positive = 1'b1;
    logic       cfg_mos_en = 1'b0;
    logic [1:0] cfg_mos_size = '0;
    logic       cfg_sepia_en = 1'b0;
    logic       out_valid, out_sol, out_sof, out_sepia;
    logic [7:0] out_luma;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    luma_fx_top u_luma_fx_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .in_luma(in_luma), .cfg_gain(cfg_gain), .cfg_gain_x2(cfg_gain_x2),
        .cfg_pedestal(cfg_pedestal), .cfg_clear(cfg_clear), .cfg_slice_en(cfg_slice_en),
        .cfg_slice_pol(cfg_slice_pol), .cfg_slice_level(cfg_slice_level),
        .cfg_sol_en(cfg_sol_en), .cfg_sol_sel(cfg_sol_sel), .cfg_positive(cfg_positive),
        .cfg_mos_en(cfg_mos_en), .cfg_mos_size(cfg_mos_size), .cfg_sepia_en(cfg_sepia_en),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof),
        .out_luma(out_luma), .out_sepia(out_sepia)
    );

    // fields: luma, gain, x2, pedestal, slice_en, slice_pol, level, sol_en, sol_sel, positive, expected
    localparam int NV = 17;
    localparam logic [44:0] VEC [NV] = '{
        {8'd100, 6'd32, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,   1'b0, 2'd0, 1'b1, 8'd100},  // R2 unity
        {8'd200, 6'd16, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,   1'b0, 2'd0, 1'b1, 8'd100},  // R2 half
        {8'd200, 6'd63, 1'b1, 8'd0,  1'b0, 1'b0, 8'd0,   1'b0, 2'd0, 1'b1, 8'd255},  // R2 limit
        {8'd50,  6'd20, 1'b1, 8'd0,  1'b0, 1'b0, 8'd0,   1'b0, 2'd0, 1'b1, 8'd62},   // R2 doubled
        {8'd100, 6'd32, 1'b0, 8'd30, 1'b0, 1'b0, 8'd0,   1'b0, 2'd0, 1'b1, 8'd130},  // R3 offset
        {8'd240, 6'd32, 1'b0, 8'd40, 1'b0, 1'b0, 8'd0,   1'b0, 2'd0, 1'b1, 8'd255},  // R3 limit
        {8'd150, 6'd32, 1'b0, 8'd0,  1'b1, 1'b1, 8'd100, 1'b0, 2'd0, 1'b1, 8'd255},  // R5 pos above
        {8'd50,  6'd32, 1'b0, 8'd0,  1'b1, 1'b1, 8'd100, 1'b0, 2'd0, 1'b1, 8'd0},    // R5 pos below
        {8'd150, 6'd32, 1'b0, 8'd0,  1'b1, 1'b0, 8'd100, 1'b0, 2'd0, 1'b1, 8'd0},    // R5 neg above
        {8'd100, 6'd32, 1'b0, 8'd0,  1'b1, 1'b1, 8'd100, 1'b0, 2'd0, 1'b1, 8'd0},    // R5 equal
        {8'd255, 6'd32, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,   1'b1, 2'd0, 1'b1, 8'd248},  // R6 three bits
        {8'd95,  6'd32, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,   1'b1, 2'd1, 1'b1, 8'd80},   // R6 four bits
        {8'd95,  6'd32, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,   1'b1, 2'd2, 1'b1, 8'd64},   // R6 five bits
        {8'd183, 6'd32, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,   1'b1, 2'd3, 1'b1, 8'd128},  // R6 six bits
        {8'd100, 6'd32, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,   1'b0, 2'd0, 1'b0, 8'd155},  // R7 negative
        {8'd100, 6'd32, 1'b0, 8'd20, 1'b1, 1'b1, 8'd110, 1'b1, 2'd0, 1'b0, 8'd7},    // R10 chain
        {8'd60,  6'd32, 1'b0, 8'd50, 1'b1, 1'b0, 8'd100, 1'b0, 2'd0, 1'b0, 8'd255}   // R10 chain
    };

    function automatic string vtag(input int i);
        if (i < 4)   return "R2";
        if (i < 6)   return "R3";
        if (i < 10)  return "R5";
        if (i < 14)  return "R6";
        if (i == 14) return "R7";
        return "R10";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_default();
        cfg_gain = 6'd32; cfg_gain_x2 = 1'b0; cfg_pedestal = '0; cfg_clear = 1'b0;
        cfg_slice_en = 1'b0; cfg_slice_pol = 1'b0; cfg_slice_level = '0;
        cfg_sol_en = 1'b0; cfg_sol_sel = '0; cfg_positive = 1'b1;
        cfg_mos_en = 1'b0; cfg_mos_size = '0; cfg_sepia_en = 1'b0;
    endtask

    // one isolated sample; returns after the result is visible
    task automatic one_pixel(input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b1; in_sol = 1'b1; in_sof = 1'b1; in_luma = v;
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] pix(input int l, input int x);
        return 8'((l * 37 + x * 5) % 256);
    endfunction

    task automatic run_mosaic(input logic [1:0] code, input int lines, input int cols);
        int n;
        int total;
        n = 4 << code;
        total = lines * cols;
        set_default();
        cfg_mos_en = 1'b1; cfg_mos_size = code;
        for (int k = 0; k < total + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                int j, l, x;
                j = k - 2; l = j / cols; x = j % cols;
                if (l % n == 0) chk("R8", out_luma, pix(l, x - x % n));
                else            chk("R9", out_luma, pix(l - l % n, x - x % n));
            end
            if (k < total) begin
                in_valid = 1'b1;
                in_sol   = (k % cols == 0);
                in_sof   = (k == 0);
                in_luma  = pix(k / cols, k % cols);
            end else begin
                in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
            end
        end
        set_default();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12", {7'd0, out_valid}, 8'd0);
        chk("R12", out_luma, 8'd0);
        chk("R12", {5'd0, out_sol, out_sof, out_sepia}, 8'd0);

        // R1: latency of exactly two edges
        @(negedge clk);
        in_valid = 1'b1; in_sol = 1'b1; in_sof = 1'b1; in_luma = 8'd77;
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
        chk("R1", {7'd0, out_valid}, 8'd0);
        @(negedge clk);
        chk("R1", {7'd0, out_valid}, 8'd1);
        chk("R1", {6'd0, out_sol, out_sof}, 8'd3);
        chk("R1", out_luma, 8'd77);
        @(negedge clk);
        chk("R1", {7'd0, out_valid}, 8'd0);

        // R2 R3 R5 R6 R7 R10: vector walk
        for (int i = 0; i < NV; i++) begin
            set_default();
            cfg_gain        = VEC[i][36:31];
            cfg_gain_x2     = VEC[i][30];
            cfg_pedestal    = VEC[i][29:22];
            cfg_slice_en    = VEC[i][21];
            cfg_slice_pol   = VEC[i][20];
            cfg_slice_level = VEC[i][19:12];
            cfg_sol_en      = VEC[i][11];
            cfg_sol_sel     = VEC[i][10:9];
            cfg_positive    = VEC[i][8];
            one_pixel(VEC[i][44:37]);
            chk(vtag(i), out_luma, VEC[i][7:0]);
        end

        // R4: clear wins over everything else
        set_default();
        cfg_clear = 1'b1; cfg_pedestal = 8'd90;
        one_pixel(8'd200);
        chk("R4", out_luma, 8'd0);
        set_default();
        one_pixel(8'd33);
        chk("R4", out_luma, 8'd33);

        // R11: sepia flag follows its sample
        cfg_sepia_en = 1'b1;
        one_pixel(8'd10);
        chk("R11", {7'd0, out_sepia}, 8'd1);
        cfg_sepia_en = 1'b0;
        one_pixel(8'd10);
        chk("R11", {7'd0, out_sepia}, 8'd0);

        // R8 R9: mosaic at several block sizes
        run_mosaic(2'd0, 8, 12);
        run_mosaic(2'd1, 16, 20);
        run_mosaic(2'd3, 33, 70);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule